// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block stands between a CPU and a shared memory port. It fetches instruction bytes ahead of execution into a small byte queue. Fetches always come from the address held in a private slave program counter, so the CPU never sends an address for sequential code. The CPU takes bytes one at a time over an 8-bit handshake. The memory side is 16 bits wide. When the address is even and there is room, one access fills two queue slots.

The same memory port also serves data accesses from the execution unit. When both want the port, the fetch side wins. At most one access is outstanding at any time. The CPU signals a change of flow (jump, call, return or interrupt) by pulsing a redirect with the new target. The block then loads the slave counter, empties the queue and discards any fetch reply still in flight. It restarts fetching from the target with a fixed, short refill delay.

Top module: `ifq_ctrl`

## Requirements
- R1: After reset the byte-valid output is low and the block requests a 16-bit fetch (`mem_word_o`=1) at address `RESET_PC`.
- R2: `ib_valid_o` is high exactly when the queue holds at least one byte. `ib_byte_o` presents the bytes in ascending address order. A byte is removed at a clock edge where `ib_take_i` and `ib_valid_o` are both high.
- R3: Every fetch uses the slave counter as its address, and the counter advances by the number of bytes fetched. A fetch is 16 bits (`mem_word_o`=1) when the address is even and at least two slots are free after in-flight bytes are counted, and 8 bits otherwise. A reply carries the byte at the fetch address in bits 7:0 and, for a 16-bit fetch, the next byte in bits 15:8.
- R4: With the queue full, and with no byte leaving in that cycle, no fetch is requested. Bytes already in flight count as occupied.
- R5: A pending fetch wins the port over an execution-unit request, and `eu_gnt_o` stays low in that cycle. When no fetch is pending, the execution-unit address, width, write flag and write data go to the port. The reply to that access appears on `eu_rvalid_o`/`eu_rdata_o`.
- R6: A redirect empties the queue and loads the slave counter at the edge where it is sampled. The next fetch is for the target address. With a ready memory and a reply one cycle after acceptance, `ib_valid_o` rises two clock edges after the redirect edge with the target byte.
- R7: A fetch reply that arrives after a redirect, for a fetch issued before it, is dropped and never reaches the queue.
- R8: A redirect overrides any enqueue or dequeue in the same cycle. The queue is empty after that edge.
- R9: At most one memory access is outstanding. A new access is requested only when none is pending, or when the pending one's reply arrives in that cycle.
- R10: No fetch is requested in a cycle where the redirect input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_i | input | 1 | Change-of-flow pulse |
| redirect_addr_i | input | AW | New fetch target |
| ib_byte_o | output | 8 | Instruction byte at queue head |
| ib_valid_o | output | 1 | Queue holds at least one byte |
| ib_take_i | input | 1 | CPU consumes the head byte |
| eu_req_i | input | 1 | Execution-unit access request |
| eu_addr_i | input | AW | Execution-unit address |
| eu_word_i | input | 1 | Execution-unit access is 16 bits |
| eu_we_i | input | 1 | Execution-unit write |
| eu_wdata_i | input | 16 | Execution-unit write data |
| eu_gnt_o | output | 1 | Execution-unit access accepted this edge |
| eu_rvalid_o | output | 1 | Reply for the execution unit |
| eu_rdata_o | output | 16 | Reply data for the execution unit |
| mem_req_o | output | 1 | Memory access request |
| mem_addr_o | output | AW | Memory address |
| mem_word_o | output | 1 | Access is 16 bits |
| mem_we_o | output | 1 | Access is a write |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this edge |
| mem_rvalid_i | input | 1 | Memory reply valid |
| mem_rdata_i | input | 16 | Memory reply data |

## Verification
The slave counter, the queue pointers and the outstanding-access record each show up at the ports within a few cycles. A counter that is off shows as a wrong byte value on `ib_byte_o` at the first byte after the fault. A wrong slot count shows either as a fetch requested while the queue is full or as `ib_valid_o` staying high past the last byte. A stale reply that is wrongly kept shows as `ib_valid_o` rising one edge early after a redirect, carrying the old stream's byte. Timing is therefore checked to the exact edge after every redirect, and every delivered byte is compared against the address it came from.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic {OWN_FETCH = 1'b0, OWN_DATA = 1'b1} owner_e;

  // A fetch fills two slots only from an even address with room for both.
  function automatic logic pick_word(input logic addr_lsb, input int room);
    return (addr_lsb == 1'b0) && (room >= 2);
  endfunction

  // Bytes delivered by one fetch.
  function automatic logic [1:0] fetch_span(input logic is_word);
    return is_word ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/ifq_byte_ring.sv
module ifq_byte_ring #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    enq_n,
  input  logic [15:0]   enq_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] count
);
  logic [7:0]    slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] wr_nxt;

  assign wr_nxt = wr_ptr + PW'(1);
  assign head   = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!flush && enq_n != 2'd0) slots[wr_ptr] <= enq_data[7:0];
    if (!flush && enq_n == 2'd2) slots[wr_nxt] <= enq_data[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(enq_n);
      if (pop) rd_ptr <= rd_ptr + PW'(1);
      count  <= count + CW'(enq_n) - CW'(pop);
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_n != 2'd0 && !flush) |-> (int'(count) + int'(enq_n) - int'(pop)) <= DEPTH);
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/ifq_tracker.sv
module ifq_tracker
  import ifq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue_fetch,
  input  logic       issue_data,
  input  logic [1:0] issue_nb,
  input  logic       kill,
  input  logic       rsp_valid,
  output logic       busy,
  output owner_e     owner,
  output logic [1:0] nb,
  output logic       dead,
  output logic [1:0] live_nb,
  output logic       slot_ok
);
  assign slot_ok = !busy || rsp_valid;
  assign live_nb = (busy && owner == OWN_FETCH && !dead) ? nb : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= OWN_FETCH;
      nb    <= 2'd0;
      dead  <= 1'b0;
    end else if (issue_fetch || issue_data) begin
      busy  <= 1'b1;
      owner <= issue_data ? OWN_DATA : OWN_FETCH;
      nb    <= issue_nb;
      dead  <= 1'b0;
    end else if (rsp_valid) begin
      busy  <= 1'b0;
      dead  <= 1'b0;
    end else if (kill && busy && owner == OWN_FETCH) begin
      dead  <= 1'b1;
    end
  end

  // r9: one access in flight
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |-> !(issue_fetch || issue_data));
  a_r7_kill_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && busy && owner == OWN_FETCH && !rsp_valid) |=> dead);
endmodule

// File: rtl/ifq_port_arb.sv
module ifq_port_arb (
  input  logic fetch_want,
  input  logic eu_req,
  input  logic slot_ok,
  input  logic ready,
  output logic port_req,
  output logic fetch_go,
  output logic eu_go
);
  assign port_req = fetch_want || (slot_ok && eu_req);
  assign fetch_go = fetch_want && ready;
  assign eu_go    = !fetch_want && slot_ok && eu_req && ready;
endmodule

// File: rtl/ifq_ctrl.sv
module ifq_ctrl
  import ifq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DEPTH    = 4,
  parameter logic [15:0] RESET_PC = 16'h0000,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_addr_i,
  output logic [7:0]    ib_byte_o,
  output logic          ib_valid_o,
  input  logic          ib_take_i,
  input  logic          eu_req_i,
  input  logic [AW-1:0] eu_addr_i,
  input  logic          eu_word_i,
  input  logic          eu_we_i,
  input  logic [15:0]   eu_wdata_i,
  output logic          eu_gnt_o,
  output logic          eu_rvalid_o,
  output logic [15:0]   eu_rdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_word_o,
  output logic          mem_we_o,
  output logic [15:0]   mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  input  logic [15:0]   mem_rdata_i
);
  logic [AW-1:0] spc;
  logic [CW-1:0] cnt;
  logic          busy, dead, slot_ok;
  owner_e        owner;
  logic [1:0]    nb, live_nb, issue_nb, enq_n;
  logic          pop_fire, use_word, fetch_want, fetch_go, eu_go, rsp_fetch;
  int            room;

  // Space after counting in-flight bytes and a byte leaving now.
  always_comb begin
    pop_fire   = ib_take_i && ib_valid_o && !redirect_i;
    room       = DEPTH - int'(cnt) - int'(live_nb) + (pop_fire ? 1 : 0);
    use_word   = pick_word(spc[0], room);
    issue_nb   = fetch_span(use_word);
    fetch_want = !redirect_i && slot_ok && (room >= 1);
  end

  assign rsp_fetch   = mem_rvalid_i && busy && owner == OWN_FETCH;
  assign enq_n       = (rsp_fetch && !dead && !redirect_i) ? nb : 2'd0;
  assign eu_rvalid_o = mem_rvalid_i && busy && owner == OWN_DATA;
  assign eu_rdata_o  = mem_rdata_i;
  assign ib_valid_o  = cnt != '0;
  assign eu_gnt_o    = eu_go;

  assign mem_addr_o  = fetch_want ? spc : eu_addr_i;
  assign mem_word_o  = fetch_want ? use_word : eu_word_i;
  assign mem_we_o    = !fetch_want && eu_we_i;
  assign mem_wdata_o = eu_wdata_i;

  always_ff @(posedge clk) begin
    if (!rst_n)          spc <= AW'(RESET_PC);
    else if (redirect_i) spc <= redirect_addr_i;
    else if (fetch_go)   spc <= spc + AW'(issue_nb);
  end

  ifq_byte_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(redirect_i), .enq_n(enq_n),
    .enq_data(mem_rdata_i), .pop(pop_fire), .head(ib_byte_o), .count(cnt)
  );

  ifq_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .issue_fetch(fetch_go), .issue_data(eu_go),
    .issue_nb(fetch_go ? issue_nb : (eu_word_i ? 2'd2 : 2'd1)),
    .kill(redirect_i), .rsp_valid(mem_rvalid_i), .busy(busy), .owner(owner),
    .nb(nb), .dead(dead), .live_nb(live_nb), .slot_ok(slot_ok)
  );

  ifq_port_arb u_arb (
    .fetch_want(fetch_want), .eu_req(eu_req_i), .slot_ok(slot_ok),
    .ready(mem_ready_i), .port_req(mem_req_o), .fetch_go(fetch_go), .eu_go(eu_go)
  );

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> cnt == '0);
  a_r6_reload_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(redirect_i) && fetch_go) |-> mem_addr_o == $past(redirect_addr_i));
  a_r7_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid_i && dead) |-> enq_n == 2'd0);
  a_r4_full_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) == DEPTH && !pop_fire) |-> !fetch_go);
  a_r5_eu_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
    eu_gnt_o |-> (mem_addr_o == eu_addr_i && !fetch_go));
  a_r10_quiet_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |-> !fetch_go);
endmodule

// File: tb/tb_ifq_ctrl.sv
module tb_ifq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic redirect = 1'b0, take = 1'b0;
  logic [15:0] redirect_addr = '0;
  logic [7:0] ib_byte;
  logic ib_valid;
  logic eu_req = 1'b0, eu_word = 1'b0, eu_we = 1'b0;
  logic [15:0] eu_addr = '0, eu_wdata = '0;
  logic eu_gnt, eu_rvalid;
  logic [15:0] eu_rdata;
  logic mem_req, mem_word, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic mem_ready = 1'b1;
  logic [1:0] tmr;
  logic [15:0] rsp_q;
  int lat_cfg = 1;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mb(input int a);
    return 8'((a * 13 + 7) & 255) ^ 8'((a >> 8) & 255);
  endfunction

  ifq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .redirect_i(redirect), .redirect_addr_i(redirect_addr),
    .ib_byte_o(ib_byte), .ib_valid_o(ib_valid), .ib_take_i(take),
    .eu_req_i(eu_req), .eu_addr_i(eu_addr), .eu_word_i(eu_word), .eu_we_i(eu_we),
    .eu_wdata_i(eu_wdata), .eu_gnt_o(eu_gnt), .eu_rvalid_o(eu_rvalid), .eu_rdata_o(eu_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_word_o(mem_word), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rvalid_i(tmr == 2'd1),
    .mem_rdata_i(rsp_q)
  );

  // Memory model: reply lat_cfg cycles after acceptance.
  always @(posedge clk) begin
    if (!rst_n) tmr <= 2'd0;
    else if (mem_req && mem_ready) begin
      tmr   <= 2'(lat_cfg);
      rsp_q <= mem_word ? {mb(int'(mem_addr) + 1), mb(int'(mem_addr))}
                        : {8'h00, mb(int'(mem_addr))};
    end else if (tmr != 2'd0) tmr <= tmr - 2'd1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Redirect and check the exact refill timing (R6, R3, R10).
  task automatic jump(input int t);
    step(); redirect = 1'b1; redirect_addr = 16'(t); take = 1'b0;
    #1 chk("R10 no fetch during redirect", 32'(mem_req), 32'(eu_req));
    step(); redirect = 1'b0;
    #1 chk("R6 target fetch addr", 32'(mem_addr), 32'(t));
    chk("R3 fetch width", 32'(mem_word), 32'(t % 2 == 0));
    chk("R8 empty after redirect", 32'(ib_valid), 0);
    for (int i = 0; i < lat_cfg; i++) begin
      step(); #1 chk("R6 no byte before refill", 32'(ib_valid), 0);
    end
    step(); #1 chk("R6 first byte valid", 32'(ib_valid), 1);
    chk("R6 first byte value", 32'(ib_byte), 32'(mb(t)));
  endtask

  // Consume n bytes from start, taking on every per-th cycle (R2).
  task automatic consume(input int start, input int n, input int per, input bit rdy_toggle);
    int k = 0;
    int ph = 0;
    while (k < n) begin
      if (rdy_toggle) mem_ready = (ph % 3) != 0;
      if (ib_valid && (ph % per == 0)) begin
        chk("R2 byte order", 32'(ib_byte), 32'(mb(start + k)));
        k++;
        take = 1'b1;
      end else take = 1'b0;
      ph++;
      step(); #1;
    end
    take = 1'b0;
    mem_ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    #1 chk("R1 valid low", 32'(ib_valid), 0);
    chk("R1 fetch req", 32'(mem_req), 1);
    chk("R1 reset addr", 32'(mem_addr), 0);
    chk("R1 word fetch", 32'(mem_word), 1);

    // Sweep targets, latencies and take rates.
    for (int l = 1; l <= 2; l++)
      for (int p = 1; p <= 3; p += 2)
        for (int t = 0; t < 12; t++) begin
          lat_cfg = l;
          jump(t);
          consume(t, 12, p, 1'b0);
        end

    // Ready stalls do not disturb the stream.
    lat_cfg = 1;
    jump(16'h10);
    consume(16'h10, 20, 1, 1'b1);

    // Fill, space accounting and port priority (R4, R3, R5).
    jump(0);
    repeat (10) step();
    #1 chk("R4 full valid", 32'(ib_valid), 1);
    chk("R4 no fetch when full", 32'(mem_req), 0);
    step(); take = 1'b1; eu_req = 1'b1; eu_addr = 16'h0120; eu_word = 1'b1; eu_we = 1'b0;
    #1 chk("R5 fetch wins", 32'(eu_gnt), 0);
    chk("R3 single slot byte fetch addr", 32'(mem_addr), 4);
    chk("R3 single slot byte width", 32'(mem_word), 0);
    step(); take = 1'b0;
    #1 chk("R5 eu granted", 32'(eu_gnt), 1);
    chk("R5 eu addr", 32'(mem_addr), 32'h0120);
    chk("R5 eu width", 32'(mem_word), 1);
    step(); eu_req = 1'b0;
    #1 chk("R5 eu reply valid", 32'(eu_rvalid), 1);
    chk("R5 eu reply data", 32'(eu_rdata), 32'({mb(16'h121), mb(16'h120)}));
    chk("R4 still full no req", 32'(mem_req), 0);
    step(); eu_req = 1'b1; eu_we = 1'b1; eu_addr = 16'h0200; eu_wdata = 16'hBEEF;
    #1 chk("R5 write granted", 32'(eu_gnt), 1);
    chk("R5 write flag", 32'(mem_we), 1);
    chk("R5 write data", 32'(mem_wdata), 32'hBEEF);
    step(); eu_req = 1'b0; eu_we = 1'b0;
    #1 chk("R5 write ack", 32'(eu_rvalid), 1);
    consume(1, 8, 1, 1'b0);

    // Stale reply after redirect (R7, R9).
    lat_cfg = 2;
    jump(16'h40);
    consume(16'h40, 3, 1, 1'b0);
    repeat (6) step();
    step(); redirect = 1'b1; redirect_addr = 16'h0060;
    step(); redirect = 1'b0;
    #1 chk("R6 target fetch addr", 32'(mem_addr), 32'h60);
    step();
    #1 chk("R9 no request while pending", 32'(mem_req), 0);
    redirect = 1'b1; redirect_addr = 16'h0081;
    step(); redirect = 1'b0;
    #1 chk("R7 refetch odd addr", 32'(mem_addr), 32'h81);
    chk("R7 byte width", 32'(mem_word), 0);
    step(); #1 chk("R7 stale reply dropped", 32'(ib_valid), 0);
    step(); #1 chk("R7 still empty", 32'(ib_valid), 0);
    step(); #1 chk("R7 new byte", 32'(ib_byte), 32'(mb(16'h81)));
    chk("R7 new byte valid", 32'(ib_valid), 1);
    consume(16'h81, 6, 1, 1'b0);

    // Redirect overriding an arriving reply (R8, R10).
    lat_cfg = 1;
    step(); redirect = 1'b1; redirect_addr = 16'h0030;
    step(); redirect = 1'b0;
    step(); redirect = 1'b1; redirect_addr = 16'h0055; take = 1'b1;
    #1 chk("R10 no fetch in redirect cycle", 32'(mem_req), 0);
    step(); redirect = 1'b0; take = 1'b0;
    #1 chk("R8 enqueue overridden", 32'(ib_valid), 0);
    chk("R8 new target addr", 32'(mem_addr), 32'h55);
    step(); #1 chk("R8 waiting refill", 32'(ib_valid), 0);
    step(); #1 chk("R8 new stream byte", 32'(ib_byte), 32'(mb(16'h55)));
    consume(16'h55, 10, 1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule